// File: doc/BRIEF.md
# PCI Option ROM Target

This block is the slice of a PCI target that answers memory cycles aimed at the device's option ROM window. It watches the shared bus for address phases, decodes them with medium timing, and claims any hit in a 1 MB window whose base comes from the configuration registers. The configuration registers are modelled here as plain inputs. A read of any width is served as a full 32-bit word. The word is gathered one byte at a time from a byte-wide parallel ROM into a scratch register. TRDY is given only once all four bytes are in place.

The ROM side presents a byte address and an active-low output enable, and takes eight data bits back. A 4-bit access-time input stretches every byte slot so that slow parts can be used. Burst read commands are served as plain single reads. Writes into the window are accepted on the bus and then dropped. If the master still holds FRAME when the data is ready, the block also drives STOP, so each transaction carries exactly one data phase. PAR is produced for every clock in which the block drives AD. An address phase is recognised even when it follows another target's last data phase with no idle clock in between.

Top module: `pci_optrom_target`

## Requirements
- R1: No cycle is claimed unless both `cfg_mem_en` and `cfg_rom_en` are 1 at the decode clock.
- R2: A cycle is in the window when address bits 31..20 equal `cfg_rom_base`. Any offset from 0 to FFFFCh is claimed, and an address one byte beyond the window or one word below it is ignored.
- R3: Commands 0110 (read), 1100 (read multiple) and 1110 (read line) are served identically as single reads. Commands 0111 and 1111 are treated as writes. Every other command code is ignored.
- R4: When the address is sampled on rising edge 0, `devsel_n` is low after edge 1 and stays low until the transaction ends. TRDY is never low without DEVSEL.
- R5: A read fetches ROM byte offsets {A[19:2],k} for k = 0,1,2,3 in that order. The byte at offset k is placed on `ad_out` bits 8k+7..8k, and the full word is returned whatever the byte enables are.
- R6: Each byte slot lasts `cfg_rom_tmg`+1 clocks, with `rom_oe_n` low throughout. For a read, `trdy_n` first goes low after edge 1+4·(`cfg_rom_tmg`+1).
- R7: For a write, `trdy_n` goes low one clock after `devsel_n`. AD is not driven, the ROM is not accessed, and a following read of the same word returns unchanged data.
- R8: If `frame_n` is still low when TRDY is given, `stop_n` is driven low together with it. DEVSEL and STOP then stay low, with TRDY high, until the master raises FRAME while IRDY is low.
- R9: `devsel_n`, `trdy_n` and `stop_n` return high one clock after the final data transfer, or after the end of the disconnect.
- R10: `par_oe` is high in the clock after each clock with `ad_oe` high. `par_out` then equals the XOR of `ad_out` and `cbe_n` from that previous clock, which gives even parity.
- R11: An address phase in the clock right after another target's final data phase, with no idle clock between them, is decoded. `fb2b_cap` is constantly 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mem_en | input | 1 | Memory space enable from the command register |
| cfg_rom_en | input | 1 | Option ROM enable bit |
| cfg_rom_base | input | 12 | Window base, address bits 31..20 |
| cfg_rom_tmg | input | 4 | Extra clocks per ROM byte slot |
| frame_n | input | 1 | Bus FRAME |
| irdy_n | input | 1 | Bus IRDY |
| ad_in | input | 32 | AD as seen on the bus |
| cbe_n | input | 4 | Command / byte enables |
| ad_out | output | 32 | Read data driven onto AD |
| ad_oe | output | 1 | AD output enable |
| devsel_n | output | 1 | DEVSEL value |
| trdy_n | output | 1 | TRDY value |
| stop_n | output | 1 | STOP value |
| tgt_oe | output | 1 | Drive enable for DEVSEL/TRDY/STOP |
| par_out | output | 1 | PAR value |
| par_oe | output | 1 | PAR output enable |
| fb2b_cap | output | 1 | Fast back-to-back capable status bit |
| rom_addr | output | 20 | ROM byte address |
| rom_oe_n | output | 1 | ROM output enable |
| rom_data | input | 8 | ROM data byte |

## Verification
The bench aims at the window edges: the last word of the window, the first byte past it, and the word just below it. A decoder with a wrong width or an off-by-one comparison would claim or drop one of these. It counts clocks from the address phase to TRDY at access times 0, 15 and random values, so a sequencer that shortened or stretched a byte slot shows up as a wrong latency. It also compares the whole word against a byte model of the ROM, which exposes swapped lanes or a wrong byte order. Further cases are a held FRAME, which must draw STOP and a clean release, a write, which must neither drive AD nor strobe the ROM, and an address phase right after a foreign data phase, which a decoder that needs an idle clock would miss.

// File: rtl/optrom_pkg.sv
package optrom_pkg;
    localparam int AD_W   = 32;
    localparam int BE_W   = 4;
    localparam int BYTE_W = 8;
    localparam int BYTES  = AD_W / BYTE_W;

    localparam logic [BE_W-1:0] CMD_MRD = 4'b0110;
    localparam logic [BE_W-1:0] CMD_MWR = 4'b0111;
    localparam logic [BE_W-1:0] CMD_MRM = 4'b1100;
    localparam logic [BE_W-1:0] CMD_MRL = 4'b1110;
    localparam logic [BE_W-1:0] CMD_MWI = 4'b1111;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DECODE,
        S_FETCH,
        S_WGAP,
        S_DATA,
        S_DRAIN
    } tstate_e;
endpackage

// File: rtl/optrom_decode.sv
module optrom_decode
    import optrom_pkg::*;
#(
    parameter int BASE_W = 12
) (
    input  logic [BASE_W-1:0] addr_hi,
    input  logic [BASE_W-1:0] base,
    input  logic [BE_W-1:0]   cmd,
    input  logic              mem_en,
    input  logic              rom_en,
    output logic              claim_rd,
    output logic              claim_wr
);
    logic open_win;
    logic is_rd;
    logic is_wr;

    always_comb begin
        open_win = mem_en && rom_en && (addr_hi == base);
        // burst read flavours alias onto the plain read
        is_rd    = (cmd == CMD_MRD) || (cmd == CMD_MRM) || (cmd == CMD_MRL);
        is_wr    = (cmd == CMD_MWR) || (cmd == CMD_MWI);
        claim_rd = open_win && is_rd;
        claim_wr = open_win && is_wr;
    end
endmodule

// File: rtl/optrom_assemble.sv
module optrom_assemble #(
    parameter int BYTES  = 4,
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      load,
    input  logic [IDX_W-1:0]          idx,
    input  logic [BYTE_W-1:0]         byte_in,
    output logic [BYTES*BYTE_W-1:0]   word
);
    logic [BYTES*BYTE_W-1:0] word_d, word_q;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign word_d[g*BYTE_W +: BYTE_W] =
            clear                       ? '0 :
            (load && idx == IDX_W'(g))  ? byte_in :
                                          word_q[g*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word = word_q;
endmodule

// File: rtl/optrom_parity.sv
module optrom_parity
    import optrom_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            drive,
    input  logic [AD_W-1:0] ad,
    input  logic [BE_W-1:0] cbe_n,
    output logic            par,
    output logic            par_oe
);
    logic par_d, par_q, oe_d, oe_q;

    always_comb begin
        par_d = ^{ad, cbe_n};
        oe_d  = drive;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            par_q <= par_d;
            oe_q  <= oe_d;
        end
    end

    assign par    = par_q;
    assign par_oe = oe_q;
endmodule

// File: rtl/pci_optrom_target.sv
module pci_optrom_target
    import optrom_pkg::*;
#(
    parameter int ROM_AW = 20,
    parameter int TMG_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_mem_en,
    input  logic                   cfg_rom_en,
    input  logic [AD_W-ROM_AW-1:0] cfg_rom_base,
    input  logic [TMG_W-1:0]       cfg_rom_tmg,
    input  logic                   frame_n,
    input  logic                   irdy_n,
    input  logic [AD_W-1:0]        ad_in,
    input  logic [BE_W-1:0]        cbe_n,
    output logic [AD_W-1:0]        ad_out,
    output logic                   ad_oe,
    output logic                   devsel_n,
    output logic                   trdy_n,
    output logic                   stop_n,
    output logic                   tgt_oe,
    output logic                   par_out,
    output logic                   par_oe,
    output logic                   fb2b_cap,
    output logic [ROM_AW-1:0]      rom_addr,
    output logic                   rom_oe_n,
    input  logic [BYTE_W-1:0]      rom_data
);
    localparam int IDX_W  = $clog2(BYTES);
    localparam int BASE_W = AD_W - ROM_AW;

    typedef struct packed {
        tstate_e               st;
        logic [AD_W-1:IDX_W]   addr;
        logic [BE_W-1:0]       cmd;
        logic                  frame_prev;
        logic                  devsel;
        logic                  trdy;
        logic                  stop;
        logic                  adoe;
        logic                  tgtoe;
        logic [IDX_W-1:0]      idx;
        logic [TMG_W-1:0]      wcnt;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st: S_IDLE, addr: '0, cmd: '0, frame_prev: 1'b1,
        devsel: 1'b0, trdy: 1'b0, stop: 1'b0, adoe: 1'b0, tgtoe: 1'b0,
        idx: '0, wcnt: '0
    };

    ctl_t r_q, r_d;
    logic claim_rd, claim_wr;
    logic asm_clear, asm_load;
    logic [AD_W-1:0] word;

    optrom_decode #(.BASE_W(BASE_W)) u_dec (
        .addr_hi  (r_q.addr[AD_W-1:ROM_AW]),
        .base     (cfg_rom_base),
        .cmd      (r_q.cmd),
        .mem_en   (cfg_mem_en),
        .rom_en   (cfg_rom_en),
        .claim_rd (claim_rd),
        .claim_wr (claim_wr)
    );

    optrom_assemble #(.BYTES(BYTES), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (asm_clear),
        .load    (asm_load),
        .idx     (r_q.idx),
        .byte_in (rom_data),
        .word    (word)
    );

    optrom_parity u_par (
        .clk    (clk),
        .rst_n  (rst_n),
        .drive  (r_q.adoe),
        .ad     (word),
        .cbe_n  (cbe_n),
        .par    (par_out),
        .par_oe (par_oe)
    );

    always_comb begin
        r_d            = r_q;
        r_d.frame_prev = frame_n;
        asm_clear      = 1'b0;
        asm_load       = 1'b0;

        unique case (r_q.st)
            S_IDLE: begin
                // a falling FRAME marks an address phase, idle clock or not
                if (!frame_n && r_q.frame_prev) begin
                    r_d.addr = ad_in[AD_W-1:IDX_W];
                    r_d.cmd  = cbe_n;
                    r_d.st   = S_DECODE;
                end
            end
            S_DECODE: begin
                if (claim_rd) begin
                    r_d.st     = S_FETCH;
                    r_d.devsel = 1'b1;
                    r_d.adoe   = 1'b1;
                    r_d.idx    = '0;
                    r_d.wcnt   = cfg_rom_tmg;
                    asm_clear  = 1'b1;
                end else if (claim_wr) begin
                    r_d.st     = S_WGAP;
                    r_d.devsel = 1'b1;
                end else begin
                    r_d.st     = S_IDLE;
                end
            end
            S_FETCH: begin
                if (r_q.wcnt == '0) begin
                    asm_load = 1'b1;
                    if (r_q.idx == IDX_W'(BYTES - 1)) begin
                        r_d.st   = S_DATA;
                        r_d.trdy = 1'b1;
                        r_d.stop = !frame_n;
                    end else begin
                        r_d.idx  = r_q.idx + 1'b1;
                        r_d.wcnt = cfg_rom_tmg;
                    end
                end else begin
                    r_d.wcnt = r_q.wcnt - 1'b1;
                end
            end
            S_WGAP: begin
                r_d.st   = S_DATA;
                r_d.trdy = 1'b1;
                r_d.stop = !frame_n;
            end
            S_DATA: begin
                if (!irdy_n) begin
                    r_d.trdy = 1'b0;
                    r_d.adoe = 1'b0;
                    if (frame_n) begin
                        r_d.st     = S_IDLE;
                        r_d.devsel = 1'b0;
                        r_d.stop   = 1'b0;
                    end else begin
                        r_d.st   = S_DRAIN;
                        r_d.stop = 1'b1;
                    end
                end
            end
            S_DRAIN: begin
                if (frame_n && !irdy_n) begin
                    r_d.st     = S_IDLE;
                    r_d.devsel = 1'b0;
                    r_d.stop   = 1'b0;
                end
            end
            default: r_d = CTL_RST;
        endcase

        // keep driving the control lines high for one turnaround clock
        r_d.tgtoe = r_d.devsel || r_q.devsel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= CTL_RST;
        else        r_q <= r_d;
    end

    assign ad_out   = word;
    assign ad_oe    = r_q.adoe;
    assign devsel_n = !r_q.devsel;
    assign trdy_n   = !r_q.trdy;
    assign stop_n   = !r_q.stop;
    assign tgt_oe   = r_q.tgtoe;
    assign fb2b_cap = 1'b1;
    assign rom_addr = {r_q.addr[ROM_AW-1:IDX_W], r_q.idx};
    assign rom_oe_n = (r_q.st != S_FETCH);
endmodule

// File: rtl/optrom_checker.sv
module optrom_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_mem_en,
    input logic cfg_rom_en,
    input logic frame_n,
    input logic irdy_n,
    input logic ad_oe,
    input logic devsel_n,
    input logic trdy_n,
    input logic stop_n,
    input logic par_oe,
    input logic rom_oe_n
);
    assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |-> $past(cfg_mem_en && cfg_rom_en));

    assert_trdy_claimed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !devsel_n);

    assert_fetch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> (trdy_n && !devsel_n));

    assert_write_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(devsel_n) && !ad_oe) |=> !trdy_n);

    assert_stop_claimed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_n |-> !devsel_n);

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n && frame_n) |=> (devsel_n && trdy_n && stop_n));

    assert_par_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe |-> $past(ad_oe));
endmodule

bind pci_optrom_target optrom_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_mem_en (cfg_mem_en),
    .cfg_rom_en (cfg_rom_en),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .ad_oe      (ad_oe),
    .devsel_n   (devsel_n),
    .trdy_n     (trdy_n),
    .stop_n     (stop_n),
    .par_oe     (par_oe),
    .rom_oe_n   (rom_oe_n)
);

// File: tb/pci_optrom_target_test.sv
module pci_optrom_target_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_en = 1'b1, rom_en = 1'b1;
    logic [11:0] rom_base = 12'hC00;
    logic [3:0]  rom_tmg = 4'd0;
    logic        frame_n = 1'b1, irdy_n = 1'b1;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic [31:0] ad_out;
    logic        ad_oe, devsel_n, trdy_n, stop_n, tgt_oe, par_out, par_oe, fb2b_cap;
    logic [19:0] rom_addr;
    logic        rom_oe_n;
    logic [7:0]  rom_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pci_optrom_target uut (
        .clk(clk), .rst_n(rst_n), .cfg_mem_en(mem_en), .cfg_rom_en(rom_en),
        .cfg_rom_base(rom_base), .cfg_rom_tmg(rom_tmg), .frame_n(frame_n),
        .irdy_n(irdy_n), .ad_in(ad_in), .cbe_n(cbe_n), .ad_out(ad_out),
        .ad_oe(ad_oe), .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
        .tgt_oe(tgt_oe), .par_out(par_out), .par_oe(par_oe), .fb2b_cap(fb2b_cap),
        .rom_addr(rom_addr), .rom_oe_n(rom_oe_n), .rom_data(rom_data)
    );

    function automatic logic [7:0] rom_byte(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'h3} ^ 8'h5A;
    endfunction

    assign rom_data = rom_byte(rom_addr);

    function automatic logic [31:0] exp_word(input logic [31:0] a);
        logic [31:0] w;
        for (int k = 0; k < 4; k++) w[8*k +: 8] = rom_byte({a[19:2], 2'(k)});
        return w;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Entered at a negedge; drives one transaction and returns at a negedge.
    task automatic run_txn(input logic [31:0] addr, input logic [3:0] cmd,
                           input logic [3:0] be, input bit hold, output bit claimed);
        bit rd, wr, hit, seen, touched, wr_drive, bad;
        int n, t;
        logic [31:0] w;
        rd  = (cmd == 4'b0110) || (cmd == 4'b1100) || (cmd == 4'b1110);
        wr  = (cmd == 4'b0111) || (cmd == 4'b1111);
        hit = mem_en && rom_en && (addr[31:20] == rom_base) && (rd || wr);
        t   = int'(rom_tmg);
        w   = exp_word(addr);
        claimed = 1'b0;
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
        @(negedge clk);
        frame_n = hold ? 1'b0 : 1'b1; irdy_n = 1'b0; cbe_n = be; ad_in = 32'h0;
        if (!hit) begin
            bad = 1'b0;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                if (devsel_n !== 1'b1 || rom_oe_n !== 1'b1) bad = 1'b1;
            end
            chk(!bad, "R1/R2/R3 unclaimed access", {31'd0, bad}, 32'd0);
            frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
            @(negedge clk);
            return;
        end
        n = 0; seen = 0; touched = 0; wr_drive = 0;
        while (!seen && n < 100) begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                claimed = (devsel_n === 1'b0);
                chk(devsel_n === 1'b0, "R4 devsel after edge 1", {31'd0, devsel_n}, 32'd0);
            end
            if (rom_oe_n === 1'b0) touched = 1;
            if (ad_oe === 1'b1 && wr) wr_drive = 1;
            if (trdy_n === 1'b0) seen = 1;
        end
        if (rd) begin
            chk(n == 1 + 4 * (t + 1), "R6 read latency", n, 1 + 4 * (t + 1));
            chk(ad_out === w && ad_oe === 1'b1, "R5 word assembly", ad_out, w);
        end else begin
            chk(n == 2 && !touched && !wr_drive, "R7 write absorbed", n, 2);
        end
        chk(stop_n === !hold, "R8 stop with trdy", {31'd0, stop_n}, {31'd0, !hold});
        if (hold) begin
            @(negedge clk);
            chk(devsel_n === 1'b0 && stop_n === 1'b0 && trdy_n === 1'b1,
                "R8 disconnect hold", {29'd0, devsel_n, stop_n, trdy_n}, 32'd1);
            frame_n = 1'b1;
        end
        @(negedge clk);
        chk(devsel_n === 1'b1 && trdy_n === 1'b1 && stop_n === 1'b1,
            "R9 release", {29'd0, devsel_n, trdy_n, stop_n}, 32'd7);
        if (rd && !hold)
            chk(par_oe === 1'b1 && par_out === ^{w, be}, "R10 parity",
                {30'd0, par_oe, par_out}, {30'd0, 1'b1, ^{w, be}});
        frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
        @(negedge clk);
    endtask

    // Another target's transaction; leaves the bus in its last data phase.
    task automatic other_target(input logic [31:0] addr);
        bit bad;
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = 4'b0110;
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b0; cbe_n = 4'h0;
        bad = 0;
        repeat (2) begin
            @(negedge clk);
            if (devsel_n !== 1'b1) bad = 1;
        end
        chk(!bad, "R2 foreign cycle ignored", {31'd0, bad}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        bit c;
        logic [3:0] cmds [6] = '{4'b0110, 4'b1100, 4'b1110, 4'b0111, 4'b1111, 4'b0010};
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(devsel_n === 1 && trdy_n === 1 && stop_n === 1 && ad_oe === 0 && rom_oe_n === 1,
            "R4 reset idle", {27'd0, devsel_n, trdy_n, stop_n, ad_oe, rom_oe_n}, 32'h1D);
        chk(fb2b_cap === 1'b1, "R11 capability bit", {31'd0, fb2b_cap}, 32'd1);

        rom_tmg = 0;  run_txn(32'hC000_0010, 4'b0110, 4'h0, 0, c);
        rom_tmg = 15; run_txn(32'hC003_4568, 4'b1100, 4'b1110, 0, c);
        rom_tmg = 3;  run_txn(32'hC00F_FFFC, 4'b1110, 4'b1100, 0, c);
        rom_tmg = 1;
        run_txn(32'hC010_0000, 4'b0110, 4'h0, 0, c);
        chk(!c, "R2 past window", {31'd0, c}, 32'd0);
        run_txn(32'hBFFF_FFFC, 4'b0110, 4'h0, 0, c);
        chk(!c, "R2 below window", {31'd0, c}, 32'd0);
        mem_en = 0; run_txn(32'hC000_0100, 4'b0110, 4'h0, 0, c);
        chk(!c, "R1 memory space off", {31'd0, c}, 32'd0);
        mem_en = 1; rom_en = 0; run_txn(32'hC000_0100, 4'b0111, 4'h0, 0, c);
        chk(!c, "R1 rom enable off", {31'd0, c}, 32'd0);
        rom_en = 1;
        run_txn(32'hC000_0100, 4'b0010, 4'h0, 0, c);
        chk(!c, "R3 io read ignored", {31'd0, c}, 32'd0);
        run_txn(32'hC000_0200, 4'b0111, 4'h0, 0, c);
        run_txn(32'hC000_0200, 4'b1111, 4'h0, 0, c);
        run_txn(32'hC000_0200, 4'b0110, 4'h0, 0, c);
        chk(c, "R7 read after write claimed", {31'd0, c}, 32'd1);
        rom_tmg = 2; run_txn(32'hC000_0044, 4'b0110, 4'h0, 1, c);
        run_txn(32'hC000_0048, 4'b0111, 4'h0, 1, c);
        other_target(32'h1234_5678);
        run_txn(32'hC000_0080, 4'b0110, 4'h0, 0, c);
        chk(c, "R11 back-to-back decode", {31'd0, c}, 32'd1);

        rom_base = 12'h7A5;
        for (int i = 0; i < 60; i++) begin
            logic [31:0] a;
            a = $urandom;
            if ($urandom_range(0, 3) != 0) a[31:20] = rom_base;
            mem_en  = ($urandom_range(0, 7) != 0);
            rom_en  = ($urandom_range(0, 7) != 0);
            rom_tmg = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 5) == 0) other_target({~rom_base, 20'h0});
            run_txn(a, cmds[$urandom_range(0, 5)], 4'($urandom), ($urandom_range(0, 3) == 0), c);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule